// File: doc/BRIEF.md
# Calendar Clock Register Bank

This block is a real-time clock that shows its time through eight byte-wide registers at the top of a 128K x 8 address space. A host reads and writes those bytes with ordinary memory cycles. Hidden BCD counters hold seconds, minutes, hours, day of week, date, month and a two-digit year. They advance once per second from a 32,768 Hz tick. They handle months of 28, 29, 30 and 31 days, and they apply a simple divisible-by-four leap rule.

The visible bytes are a copy of the counters. The copy is refreshed as a whole one cycle after each second boundary. Setting the freeze bit (bit 6) of the control byte stops the refresh, so software can read a consistent time while the counters keep running. While the copy is frozen, software can write new values into the clock bytes. When the freeze bit is cleared, only the fields that were written are loaded into the counters. The next refresh then comes one full second after the release.

A four-state machine sets when the copy is refreshed:
- **S_RUN**: normal refreshing.
- **S_COPY**: the single cycle that copies the counters.
- **S_HALT**: the copy is frozen.
- **S_WAIT**: the one-second hold-off after release.

Its transitions are:
- RUN→COPY on a second boundary.
- RUN→HALT when the freeze bit is written as 1.
- COPY→HALT or COPY→RUN, depending on the freeze bit once the copy is done.
- HALT→WAIT when the freeze bit is written as 0.
- WAIT→COPY when the hold-off second expires.
- WAIT→HALT when the freeze bit is written as 1 again.

Top module: `rtc_regbank`

## Requirements
- R1: The block decodes addresses BASE+0 to BASE+7, with BASE = 1FFF8h. Offset 0 is the control byte. Offsets 1 to 7 are second, minute, hour, day of week, date, month and year. Any other address, or a cycle with chip select low, reads 00h. Read data is combinational from the address.
- R2: After reset the clock bytes read 00 s, 00 min, 00 h, day 01, date 01, month 01, year 00, and the control byte reads 00h.
- R3: Seconds and minutes count 00 to 59 in BCD, and hours count 00 to 23. Each carries into the next field when it wraps. The midnight wrap advances both day of week and date.
- R4: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 29 when the year is divisible by 4 (including 00), and after 28 otherwise.
- R5: Day of week counts 1 to 7 and then returns to 1. Month counts 01 to 12 and carries into the year. Year counts 00 to 99 and then returns to 00.
- R6: The counters advance once every TICKS_PER_SEC tick pulses. All seven visible bytes take the new counter values together, one cycle after the counters step.
- R7: Bit 6 of the control byte is the freeze bit. While it is 1, the visible bytes hold their value. The control byte reads back 40h while frozen and 00h otherwise; all other control bits read 0.
- R8: The hidden counters keep advancing while the copy is frozen.
- R9: A refresh that is due in the same cycle that the freeze bit is written still completes.
- R10: After the freeze bit is cleared, the visible bytes do not change until TICKS_PER_SEC further tick pulses have passed. Then they are refreshed.
- R11: While frozen, a write to a clock byte changes that visible byte. On release, only the written fields are loaded into the counters. If any field was loaded, the tick prescaler restarts.
- R12: Writes to clock bytes while the freeze bit is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per 32,768 Hz oscillator period |
| bus_cs | input | 1 | Chip select for the byte access |
| bus_we | input | 1 | Write strobe (1 = write) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |

## Verification
A table of starting times is loaded through the freeze/write/release path and run forward one to three seconds. The table covers:
- a plain minute carry;
- month ends of 30 and 31 days;
- February in a leap year, in a common year, and in year 00;
- the year 99 to 00 wrap;
- the day-of-week 7 to 1 wrap.

Each row separates a correct month-length or carry decision from an off-by-one one.

Directed sequences check the freeze-related behaviour:
- A freeze held across several seconds separates a frozen copy from a live one.
- A release without writes separates counters that kept running from counters that stopped.
- A freeze written in the exact refresh cycle separates a completed refresh from an interrupted one.
- A single-field write separates per-field loading from whole-snapshot loading.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_COPY = 2'd1,
        S_HALT = 2'd2,
        S_WAIT = 2'd3
    } view_state_e;

    localparam int NFIELD    = 7;
    localparam int FREEZE_BIT = 6;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        logic [7:0] bin;
        bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        if (mon == 8'h02) return is_leap(yr) ? 8'h29 : 8'h28;
        if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
        return 8'h31;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign done = tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (done)   cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + CW'(1);
    end

    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_pulse_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr && TICKS > 1) |=> !done);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                load_en,
    input  logic [NFIELD-1:0]   load_mask,
    input  rtc_time_t           load_val,
    output rtc_time_t           now
);
    localparam rtc_time_t RESET_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                          day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

    rtc_time_t cur_q, stepped, nxt;

    always_comb begin
        stepped = cur_q;
        if (cur_q.sec != 8'h59) begin
            stepped.sec = bcd_inc(cur_q.sec);
        end else begin
            stepped.sec = 8'h00;
            if (cur_q.min != 8'h59) begin
                stepped.min = bcd_inc(cur_q.min);
            end else begin
                stepped.min = 8'h00;
                if (cur_q.hr != 8'h23) begin
                    stepped.hr = bcd_inc(cur_q.hr);
                end else begin
                    stepped.hr  = 8'h00;
                    stepped.day = (cur_q.day == 8'h07) ? 8'h01 : bcd_inc(cur_q.day);
                    if (cur_q.date != month_len(cur_q.mon, cur_q.yr)) begin
                        stepped.date = bcd_inc(cur_q.date);
                    end else begin
                        stepped.date = 8'h01;
                        if (cur_q.mon != 8'h12) begin
                            stepped.mon = bcd_inc(cur_q.mon);
                        end else begin
                            stepped.mon = 8'h01;
                            stepped.yr  = (cur_q.yr == 8'h99) ? 8'h00 : bcd_inc(cur_q.yr);
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        logic [8*NFIELD-1:0] v, lv;
        v  = cur_q;
        lv = load_val;
        if (load_en) begin
            for (int k = 0; k < NFIELD; k++) begin
                if (load_mask[k]) v[8*k +: 8] = lv[8*k +: 8];
            end
        end else if (step) begin
            v = stepped;
        end
        nxt = v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= RESET_TIME;
        else        cur_q <= nxt;
    end

    assign now = cur_q;

    p_sec_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.sec[3:0] <= 4'd9) && (cur_q.sec <= 8'h59));

    p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.hr[3:0] <= 4'd9) && (cur_q.hr <= 8'h23));

    p_date_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.date != 8'h00) && (cur_q.date <= 8'h31));

    p_day_mon_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.day >= 8'h01) && (cur_q.day <= 8'h07) &&
        (cur_q.mon >= 8'h01) && (cur_q.mon <= 8'h12));

endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int                ADDR_W        = 17,
    parameter int                TICKS_PER_SEC = 32768,
    parameter logic [ADDR_W-1:0] BASE          = ADDR_W'(17'h1FFF8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int VW = 8 * NFIELD;

    view_state_e state_q, state_d;

    logic              read_q;
    logic [VW-1:0]     vis_q;
    logic [NFIELD-1:0] dirty_q;
    rtc_time_t         now;

    logic       hit, wr, ctrl_wr, clk_wr, set_read, release_rd, read_nxt;
    logic [2:0] off, fidx;
    logic       sec_pulse, dly_done, load_en, copy_en, dly_tick;

    // Bus decode
    assign hit        = bus_cs && (bus_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
    assign off        = bus_addr[2:0];
    assign fidx       = off - 3'd1;
    assign wr         = hit && bus_we;
    assign ctrl_wr    = wr && (off == 3'd0);
    assign clk_wr     = wr && (off != 3'd0) && read_q;
    assign set_read   = ctrl_wr && bus_wdata[FREEZE_BIT];
    assign release_rd = ctrl_wr && !bus_wdata[FREEZE_BIT] && read_q;
    assign read_nxt   = ctrl_wr ? bus_wdata[FREEZE_BIT] : read_q;
    assign load_en    = release_rd && (|dirty_q);

    // Time base and release hold-off
    rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_sec_div (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(load_en), .done(sec_pulse)
    );

    rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_holdoff (
        .clk(clk), .rst_n(rst_n), .tick(dly_tick), .clr(release_rd), .done(dly_done)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .step(sec_pulse), .load_en(load_en),
        .load_mask(dirty_q), .load_val(rtc_time_t'(vis_q)), .now(now)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:  if (sec_pulse)      state_d = S_COPY;
                    else if (set_read)  state_d = S_HALT;
            S_COPY: state_d = read_nxt ? S_HALT : S_RUN;
            S_HALT: if (release_rd)     state_d = S_WAIT;
            S_WAIT: if (set_read)       state_d = S_HALT;
                    else if (dly_done)  state_d = S_COPY;
            default: state_d = S_RUN;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        copy_en  = (state_q == S_COPY);
        dly_tick = tick && (state_q == S_WAIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) read_q <= 1'b0;
        else        read_q <= read_nxt;
    end

    // Visible bytes and per-field dirty flags
    for (genvar k = 0; k < NFIELD; k++) begin : g_field
        localparam logic [7:0] RST_V = (k == 3 || k == 4 || k == 5) ? 8'h01 : 8'h00;
        logic sel;
        assign sel = clk_wr && (fidx == 3'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       vis_q[8*k +: 8] <= RST_V;
            else if (copy_en) vis_q[8*k +: 8] <= now[8*k +: 8];
            else if (sel)     vis_q[8*k +: 8] <= bus_wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          dirty_q[k] <= 1'b0;
            else if (release_rd) dirty_q[k] <= 1'b0;
            else if (sel)        dirty_q[k] <= 1'b1;
        end
    end

    // Read mux
    always_comb begin
        if (!hit)             bus_rdata = 8'h00;
        else if (off == 3'd0) bus_rdata = {1'b0, read_q, 6'b0};
        else                  bus_rdata = 8'(vis_q >> {fidx, 3'b000});
    end

    p_vis_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_COPY && !clk_wr) |=> $stable(vis_q));

    p_halt_no_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> (state_q != S_COPY));

    p_copy_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COPY) |-> ($past(state_q) == S_RUN || $past(state_q) == S_WAIT));

    p_ignored_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off != 3'd0 && !read_q && state_q != S_COPY) |=> $stable(vis_q));

    p_ctrl_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && off == 3'd0) |-> ((bus_rdata & 8'hBF) == 8'h00));

endmodule

// File: tb/rtc_regbank_tb.sv
module rtc_regbank_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          TPS        = 8;
    localparam logic [16:0] BASE       = 17'h1FFF8;
    localparam int          NVEC       = 8;

    // Vectors: {yr,mon,date,day,hr,min,sec}
    localparam logic [55:0] V_START [NVEC] = '{
        56'h23061503000058, 56'h24022807235959, 56'h23022802235959, 56'h21043004235959,
        56'h99123105235959, 56'h00022901235959, 56'h22013103125959, 56'h19073106235959};
    localparam int          V_SECS  [NVEC] = '{3, 1, 1, 1, 1, 1, 2, 1};
    localparam logic [55:0] V_EXP   [NVEC] = '{
        56'h23061503000101, 56'h24022901000000, 56'h23030103000000, 56'h21050105000000,
        56'h00010106000000, 56'h00030102000000, 56'h22013103130001, 56'h19080107000000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_cs = 1'b0;
    logic        bus_we = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regbank #(.ADDR_W(17), .TICKS_PER_SEC(TPS), .BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [55:0] act, input logic [55:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = BASE + 17'(off); bus_wdata = d;
        @(posedge clk);
        #1 bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read_addr(input logic [16:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_cs = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] off, output logic [7:0] d);
        bus_read_addr(BASE + 17'(off), d);
    endtask

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b;
        for (int k = 0; k < 7; k++) begin
            bus_read(3'(k + 1), b);
            t[8*k +: 8] = b;
        end
    endtask

    // Freeze, write every field, release; returns just after the release edge
    task automatic load_time(input logic [55:0] t);
        bus_write(3'd0, 8'h40);
        for (int k = 0; k < 7; k++) bus_write(3'(k + 1), t[8*k +: 8]);
        bus_write(3'd0, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [55:0] t;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: reset contents
        bus_read(3'd0, b); check(b == 8'h00, "R2 ctrl", 56'(b), 56'h00);
        read_time(t);      check(t == 56'h00010101000000, "R2 time", t, 56'h00010101000000);

        // R1: addresses outside the window and deselected cycles read zero
        bus_read_addr(17'h00000, b); check(b == 8'h00, "R1 low addr", 56'(b), 56'h00);
        bus_read_addr(17'h1FFF7, b); check(b == 8'h00, "R1 below base", 56'(b), 56'h00);
        @(negedge clk); bus_cs = 1'b0; bus_addr = BASE + 17'd4;
        #1 check(bus_rdata == 8'h00, "R1 no select", 56'(bus_rdata), 56'h00);

        @(negedge clk) tick = 1'b1;

        // R3 R4 R5 R6: table walk
        for (int v = 0; v < NVEC; v++) begin
            load_time(V_START[v]);
            repeat (V_SECS[v] * TPS + 3) @(posedge clk);
            bus_write(3'd0, 8'h40);
            read_time(t);
            check(t == V_EXP[v], $sformatf("R3/R4/R5/R6 vector %0d", v), t, V_EXP[v]);
            bus_write(3'd0, 8'h00);
        end

        // R7 R8 R10 R12: freeze, hold, release without writes
        load_time(56'h20051503101010);
        repeat (2 * TPS + 3) @(posedge clk);
        bus_write(3'd0, 8'hFF);
        bus_read(3'd1, b); check(b == 8'h12, "R7 frozen snapshot", 56'(b), 56'h12);
        bus_read(3'd0, b); check(b == 8'h40, "R7 ctrl readback", 56'(b), 56'h40);
        repeat (3 * TPS) @(posedge clk);
        bus_read(3'd1, b); check(b == 8'h12, "R7 still frozen", 56'(b), 56'h12);
        bus_write(3'd0, 8'h00);
        bus_write(3'd1, 8'h45);
        bus_read(3'd1, b); check(b == 8'h12, "R10 R12 no early refresh, write ignored", 56'(b), 56'h12);
        bus_read(3'd0, b); check(b == 8'h00, "R7 ctrl cleared", 56'(b), 56'h00);
        repeat (TPS + 4) @(posedge clk);
        bus_read(3'd1, b);
        check(b >= 8'h16 && b <= 8'h18, "R8 R10 counters ran during freeze", 56'(b), 56'h17);
        check(b != 8'h45, "R12 ignored write absent", 56'(b), 56'h17);

        // R9: freeze written in the refresh cycle does not cancel it
        load_time(56'h20051503111120);
        repeat (TPS) @(posedge clk);
        bus_write(3'd0, 8'h40);
        bus_read(3'd1, b); check(b == 8'h21, "R9 refresh completes", 56'(b), 56'h21);

        // R11: only the written field is loaded
        bus_write(3'd2, 8'h42);
        bus_read(3'd2, b); check(b == 8'h42, "R11 visible write", 56'(b), 56'h42);
        bus_write(3'd0, 8'h00);
        repeat (TPS + 3) @(posedge clk);
        bus_write(3'd0, 8'h40);
        bus_read(3'd2, b); check(b == 8'h42, "R11 minute loaded", 56'(b), 56'h42);
        bus_read(3'd3, b); check(b == 8'h11, "R11 hour untouched", 56'(b), 56'h11);
        bus_read(3'd1, b);
        check(b >= 8'h22 && b <= 8'h24, "R11 seconds kept running", 56'(b), 56'h23);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule